// File: doc/BRIEF.md
# PHY Management Register File

This block holds the management registers of a Fast Ethernet PHY as a station manager sees them through a parallel read/write port. A request carries a 5-bit PHY address, a 5-bit register index, a 16-bit write value and a read or write strobe. Only requests whose address matches the `PHY_ADDR` parameter reach the registers. Reads to any other address return all ones, and writes to any other address do nothing.

The block holds six registers: control, status, two fixed identifiers, ability advertisement and link-partner ability. Status and partner ability are not stored. They are built from a registered copy of the `link_i` input, so they follow the link one cycle after it changes. Writing the control register with its self-clear bit (bit 15) set restores every default, and status and partner ability then reflect the current link again. Read data is registered: it updates at the clock edge that samples `rd_i` and holds between reads.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset, control (index 0) reads 0x3100 and advertisement (index 4) reads 0x01E1.
- R2: Status (index 1) reads 0x786C while the registered link is up and 0x7848 while it is down. Bit 2 is link status and bit 5 is negotiation complete.
- R3: Partner ability (index 5) reads 0x01E0 while the registered link is up and 0x0080 while it is down.
- R4: A change on `link_i` is visible to a read issued one cycle later. A read strobed at the same edge that samples the change still returns the old value.
- R5: A read whose PHY address differs from `PHY_ADDR` returns 0xFFFF. A write to such an address changes no register.
- R6: A control write with bit 15 clear stores bits 14:0, and bit 15 reads 0. An advertisement write stores all 16 bits.
- R7: A control write with bit 15 set reloads control to 0x3100 and advertisement to 0x01E1, whatever the write value. Status and partner ability then reflect the current link.
- R8: Writes to status, identifier, partner-ability and unimplemented indices change nothing that can be read.
- R9: Index 2 reads `PHY_ID_HI` and index 3 reads `PHY_ID_LO`. Every index from 6 to 31 reads 0x0000.
- R10: `rdata_o` changes only at a clock edge where `rd_i` is high, and holds its value otherwise, including across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phy_addr_i | input | 5 | PHY address of the request |
| reg_idx_i | input | 5 | Register index of the request |
| wdata_i | input | 16 | Write value |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| link_i | input | 1 | Link status, 1 = up |
| rdata_o | output | 16 | Registered read data |

## Verification
The hardest case to reach is the one-cycle window in R4: a read must be strobed at exactly the edge that first samples a new `link_i` level. The bench changes `link_i` and raises `rd_i` on the same falling edge, and expects the old status value. It then reads again and expects the new value. The soft reset is exercised while the link is down, to show that reloaded defaults do not bring back link-up status bits.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned IDX_W  = 5;

  localparam logic [IDX_W-1:0] IDX_CTRL = 5'd0;
  localparam logic [IDX_W-1:0] IDX_STAT = 5'd1;
  localparam logic [IDX_W-1:0] IDX_ID_H = 5'd2;
  localparam logic [IDX_W-1:0] IDX_ID_L = 5'd3;
  localparam logic [IDX_W-1:0] IDX_ADV  = 5'd4;
  localparam logic [IDX_W-1:0] IDX_LPA  = 5'd5;

  // control bits
  localparam int unsigned CTL_SRST  = 15;
  localparam int unsigned CTL_SPD   = 13;
  localparam int unsigned CTL_ANEN  = 12;
  localparam int unsigned CTL_FDX   = 8;

  // status bits
  localparam int unsigned ST_100FD  = 14;
  localparam int unsigned ST_100HD  = 13;
  localparam int unsigned ST_10FD   = 12;
  localparam int unsigned ST_10HD   = 11;
  localparam int unsigned ST_PRSUP  = 6;
  localparam int unsigned ST_ANDONE = 5;
  localparam int unsigned ST_ANCAP  = 3;
  localparam int unsigned ST_LINK   = 2;

  // ability bits (advertisement and partner)
  localparam int unsigned AB_100FD  = 8;
  localparam int unsigned AB_100    = 7;
  localparam int unsigned AB_10FD   = 6;
  localparam int unsigned AB_10     = 5;
  localparam logic [4:0]  AB_SEL    = 5'b00001;

  localparam logic [DATA_W-1:0] CTRL_DEF =
      (16'd1 << CTL_SPD) | (16'd1 << CTL_ANEN) | (16'd1 << CTL_FDX);
  localparam logic [DATA_W-1:0] STAT_BASE =
      (16'd1 << ST_100FD) | (16'd1 << ST_100HD) | (16'd1 << ST_10FD) |
      (16'd1 << ST_10HD) | (16'd1 << ST_PRSUP) | (16'd1 << ST_ANCAP);
  localparam logic [DATA_W-1:0] STAT_UP =
      (16'd1 << ST_LINK) | (16'd1 << ST_ANDONE);
  localparam logic [DATA_W-1:0] ADV_DEF =
      (16'd1 << AB_100FD) | (16'd1 << AB_100) | (16'd1 << AB_10FD) |
      (16'd1 << AB_10) | {11'd0, AB_SEL};
  localparam logic [DATA_W-1:0] LPA_DOWN = (16'd1 << AB_100);
  localparam logic [DATA_W-1:0] LPA_UP =
      (16'd1 << AB_100FD) | (16'd1 << AB_10FD) | (16'd1 << AB_10);

  localparam logic [DATA_W-1:0] RD_FLOAT = {DATA_W{1'b1}};
endpackage

// File: rtl/phy_mgmt_decode.sv
module phy_mgmt_decode
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter logic [ADDR_W-1:0] PHY_ADDR = '0
) (
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic              wr_i,
  input  logic              wsrst_i,
  output logic              hit_o,
  output logic              ctrl_we_o,
  output logic              adv_we_o,
  output logic              srst_o
);
  logic wr_hit;

  assign hit_o  = (phy_addr_i == PHY_ADDR);
  assign wr_hit = wr_i && hit_o;

  always_comb begin
    ctrl_we_o = 1'b0;
    adv_we_o  = 1'b0;
    srst_o    = 1'b0;
    if (wr_hit) begin
      unique case (reg_idx_i)
        IDX_CTRL: begin
          srst_o    = wsrst_i;
          ctrl_we_o = !wsrst_i;
        end
        IDX_ADV:  adv_we_o = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    AST_ONE_TARGET: assert ($onehot0({ctrl_we_o, adv_we_o, srst_o})); // R8
  end
endmodule

// File: rtl/phy_mgmt_cfg_regs.sv
module phy_mgmt_cfg_regs
  import phy_mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              adv_we_i,
  input  logic              srst_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] adv_o
);
  logic [DATA_W-1:0] ctrl_q, adv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_DEF;
      adv_q  <= ADV_DEF;
    end else if (srst_i) begin
      ctrl_q <= CTRL_DEF;
      adv_q  <= ADV_DEF;
    end else begin
      if (ctrl_we_i) ctrl_q <= wdata_i & ~(16'd1 << CTL_SRST);
      if (adv_we_i)  adv_q  <= wdata_i;
    end
  end

  assign ctrl_o = ctrl_q;
  assign adv_o  = adv_q;

  AST_SRST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (ctrl_q == CTRL_DEF) && (adv_q == ADV_DEF)); // R7
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_we_i || adv_we_i || srst_i) |=> $stable(ctrl_q) && $stable(adv_q)); // R8
endmodule

// File: rtl/phy_mgmt_link_stat.sv
module phy_mgmt_link_stat
  import phy_mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_i,
  output logic [DATA_W-1:0] stat_o,
  output logic [DATA_W-1:0] lpa_o
);
  logic link_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) link_q <= 1'b0;
    else         link_q <= link_i;
  end

  assign stat_o = link_q ? (STAT_BASE | STAT_UP) : STAT_BASE;
  assign lpa_o  = link_q ? (LPA_DOWN | LPA_UP) : LPA_DOWN;
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter logic [ADDR_W-1:0] PHY_ADDR = 5'd1,
  parameter logic [15:0] PHY_ID_HI = 16'h02A5,
  parameter logic [15:0] PHY_ID_LO = 16'h5C91
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              link_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic              hit, ctrl_we, adv_we, srst;
  logic [DATA_W-1:0] ctrl, adv, stat, lpa, rd_mux, rdata_q;

  phy_mgmt_decode #(.ADDR_W(ADDR_W), .PHY_ADDR(PHY_ADDR)) u_dec (
    .phy_addr_i (phy_addr_i),
    .reg_idx_i  (reg_idx_i),
    .wr_i       (wr_i),
    .wsrst_i    (wdata_i[CTL_SRST]),
    .hit_o      (hit),
    .ctrl_we_o  (ctrl_we),
    .adv_we_o   (adv_we),
    .srst_o     (srst)
  );

  phy_mgmt_cfg_regs u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_we_i (ctrl_we),
    .adv_we_i  (adv_we),
    .srst_i    (srst),
    .wdata_i   (wdata_i),
    .ctrl_o    (ctrl),
    .adv_o     (adv)
  );

  phy_mgmt_link_stat u_lnk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .link_i (link_i),
    .stat_o (stat),
    .lpa_o  (lpa)
  );

  always_comb begin
    if (!hit) rd_mux = RD_FLOAT;
    else begin
      unique case (reg_idx_i)
        IDX_CTRL: rd_mux = ctrl;
        IDX_STAT: rd_mux = stat;
        IDX_ID_H: rd_mux = PHY_ID_HI;
        IDX_ID_L: rd_mux = PHY_ID_LO;
        IDX_ADV:  rd_mux = adv;
        IDX_LPA:  rd_mux = lpa;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  AST_MISS_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (phy_addr_i != PHY_ADDR)) |=> rdata_o == 16'hFFFF); // R5
  AST_ID_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && hit && reg_idx_i == IDX_ID_H) |=> rdata_o == PHY_ID_HI); // R9
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R10
  AST_LPA_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat[ST_LINK] == (lpa == (LPA_DOWN | LPA_UP))); // R3
endmodule

// File: tb/sim_phy_mgmt_regs.sv
module sim_phy_mgmt_regs;
  localparam logic [4:0]  MY_ADDR = 5'd1;
  localparam logic [15:0] ID_H = 16'h02A5;
  localparam logic [15:0] ID_L = 16'h5C91;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic [4:0]  idx = '0;
  logic [15:0] wdata = '0;
  logic        rd = 1'b0, wr = 1'b0, link = 1'b1;
  logic [15:0] rdata;
  int          n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  phy_mgmt_regs #(.PHY_ADDR(MY_ADDR), .PHY_ID_HI(ID_H), .PHY_ID_LO(ID_L)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .phy_addr_i(addr), .reg_idx_i(idx),
    .wdata_i(wdata), .rd_i(rd), .wr_i(wr), .link_i(link), .rdata_o(rdata)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [4:0] a, input logic [4:0] i, input logic [15:0] d);
    addr = a; idx = i; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_rd(input logic [4:0] a, input logic [4:0] i, output logic [15:0] d);
    addr = a; idx = i; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] i, input logic [15:0] exp);
    logic [15:0] v;
    do_rd(MY_ADDR, i, v);
    check(tag, v, exp);
  endtask

  task automatic t_reset;
    check("R10 reset rdata", rdata, 16'h0000);
    rd_chk("R1 ctrl default", 5'd0, 16'h3100);
    rd_chk("R1 adv default", 5'd4, 16'h01E1);
    rd_chk("R2 status up", 5'd1, 16'h786C);
    rd_chk("R3 partner up", 5'd5, 16'h01E0);
    rd_chk("R9 id hi", 5'd2, ID_H);
    rd_chk("R9 id lo", 5'd3, ID_L);
    rd_chk("R9 idx6 zero", 5'd6, 16'h0000);
    rd_chk("R9 idx31 zero", 5'd31, 16'h0000);
  endtask

  task automatic t_link;
    link = 1'b0;
    rd_chk("R4 same-edge read old", 5'd1, 16'h786C);
    rd_chk("R2 status down", 5'd1, 16'h7848);
    rd_chk("R3 partner down", 5'd5, 16'h0080);
    link = 1'b1;
    rd_chk("R4 same-edge partner old", 5'd5, 16'h0080);
    rd_chk("R2 status up again", 5'd1, 16'h786C);
  endtask

  task automatic t_addr;
    logic [15:0] v;
    do_rd(5'd7, 5'd0, v);
    check("R5 miss read ctrl", v, 16'hFFFF);
    do_rd(5'd0, 5'd2, v);
    check("R5 miss read id", v, 16'hFFFF);
    do_wr(5'd7, 5'd0, 16'h0000);
    do_wr(5'd2, 5'd4, 16'h0000);
    rd_chk("R5 miss write ctrl", 5'd0, 16'h3100);
    rd_chk("R5 miss write adv", 5'd4, 16'h01E1);
  endtask

  task automatic t_write;
    do_wr(MY_ADDR, 5'd0, 16'h1000);
    rd_chk("R6 ctrl store", 5'd0, 16'h1000);
    do_wr(MY_ADDR, 5'd0, 16'h7FFF);
    rd_chk("R6 ctrl bit15 zero", 5'd0, 16'h7FFF);
    do_wr(MY_ADDR, 5'd4, 16'hFFFF);
    rd_chk("R6 adv store", 5'd4, 16'hFFFF);
    do_wr(MY_ADDR, 5'd4, 16'h0021);
    rd_chk("R6 adv store2", 5'd4, 16'h0021);
  endtask

  task automatic t_ro;
    do_wr(MY_ADDR, 5'd1, 16'h0000);
    do_wr(MY_ADDR, 5'd2, 16'h0000);
    do_wr(MY_ADDR, 5'd3, 16'hFFFF);
    do_wr(MY_ADDR, 5'd5, 16'h0000);
    do_wr(MY_ADDR, 5'd9, 16'hFFFF);
    rd_chk("R8 status ro", 5'd1, 16'h786C);
    rd_chk("R8 id hi ro", 5'd2, ID_H);
    rd_chk("R8 id lo ro", 5'd3, ID_L);
    rd_chk("R8 partner ro", 5'd5, 16'h01E0);
    rd_chk("R8 idx9 ro", 5'd9, 16'h0000);
    rd_chk("R8 ctrl untouched", 5'd0, 16'h7FFF);
    rd_chk("R8 adv untouched", 5'd4, 16'h0021);
  endtask

  task automatic t_srst;
    link = 1'b0;
    do_wr(MY_ADDR, 5'd0, 16'h0000);
    do_wr(MY_ADDR, 5'd4, 16'h0001);
    do_wr(MY_ADDR, 5'd0, 16'h8000);
    rd_chk("R7 ctrl reload", 5'd0, 16'h3100);
    rd_chk("R7 adv reload", 5'd4, 16'h01E1);
    rd_chk("R7 status link down", 5'd1, 16'h7848);
    rd_chk("R7 partner link down", 5'd5, 16'h0080);
    do_wr(MY_ADDR, 5'd0, 16'hC0FF);
    rd_chk("R7 ctrl reload any value", 5'd0, 16'h3100);
    link = 1'b1;
  endtask

  task automatic t_hold;
    rd_chk("R10 id read", 5'd3, ID_L);
    idx = 5'd0; addr = 5'd9;
    @(negedge clk);
    check("R10 hold idle", rdata, ID_L);
    do_wr(MY_ADDR, 5'd4, 16'h1234);
    check("R10 hold across write", rdata, ID_L);
    link = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R10 hold across link", rdata, ID_L);
    link = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_link;
    t_addr;
    t_write;
    t_ro;
    t_srst;
    t_hold;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule